// File: doc/BRIEF.md
# Sparse Row-Compressed Matrix-Vector Multiplier

The block computes y = M·x, where M is a 16x16 signed matrix with exactly four nonzero entries in every row and x is a dense 16-entry signed vector. M is kept in compressed-row form. One store holds the nonzero values, and a second holds the 4-bit column index of each value. A row-start table with 17 entries, where row r begins at entry 4·r, gives each row's first slot. The vector sits in a small register file. All three stores are filled through a single shared load port while the block is idle.

A start pulse launches a pass. In each cycle one row is issued. Four lanes each fetch one nonzero value and its column index, use the index to select a vector element, and register the product. In the next cycle an adder tree reduces the four products, and the 19-bit row result is written into an output memory. A host can read that memory at any time through a combinational read port. A cycle counter measures the pass, and a done flag marks its end.

Top module: `spmv_csr_top`

## Requirements
- R1: After reset, done is 0 and cycle_count is 0.
- R2: After a pass, output word r holds the sum over the four slots k = 4·r .. 4·r+3 of value[k] × x[colidx[k]], as a 19-bit two's-complement number. Values and vector entries are 8-bit signed.
- R3: Extreme operands (all -128, or -128 mixed with 127) give exact results without wrap.
- R4: Starting from idle or done, cycle_count reads 0 one cycle after start is sampled. It then rises by one each cycle. done rises together with cycle_count = 17, i.e. 17 cycles after the start edge.
- R5: Once done is 1 and no new start arrives, done stays 1 and cycle_count holds.
- R6: A start pulse during a pass is ignored, and the pass still ends at cycle_count = 17 with correct results.
- R7: Loads are accepted only while no pass runs. ld_sel selects the target: 0 for the vector (index in ld_addr[3:0]), 1 for the nonzero values, 2 for the column indices (ld_data[3:0]), and 3 for nothing. A load issued during a pass changes nothing.
- R8: Reset clears neither the loaded matrix and vector nor the output memory.
- R9: Repeated column indices within one row are each multiplied and summed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of control state |
| start | input | 1 | Launch a pass when idle or done |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 2 | Load target: 0 vector, 1 values, 2 column indices, 3 none |
| ld_addr | input | 6 | Load slot (vector uses low 4 bits) |
| ld_data | input | 8 | Load data (column index uses low 4 bits) |
| rd_addr | input | 4 | Output memory read row |
| rd_data | output | 19 | Signed result of row rd_addr |
| done | output | 1 | Pass complete |
| cycle_count | output | 11 | Cycles elapsed in the current or last pass |

## Verification
Each fault shows up in a particular way at the ports. A wrong row-start pointer or lane offset corrupts whole output rows. A bad column-index path moves errors to the rows whose indices hit the faulty element. Both are visible on the first pass, as soon as the sixteen words are read back. An off-by-one in the issue counter or the pipeline valid shifts the done edge away from count 17, or leaves the last row stale. Sweeps with random, extreme and duplicate-index data, together with stores left unchanged across reset, expose these faults within one pass of about twenty cycles.

// File: rtl/spmv_pkg.sv
package spmv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } spmv_state_e;

   typedef enum logic [1:0] {
      LD_VEC  = 2'd0,
      LD_VAL  = 2'd1,
      LD_COL  = 2'd2,
      LD_NONE = 2'd3
   } spmv_ld_e;
endpackage

// File: rtl/spmv_store.sv
module spmv_store #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 8,
   parameter int AW    = 6,
   parameter int PORTS = 4
) (
   input  logic                   clk,
   input  logic                   we,
   input  logic [AW-1:0]          waddr,
   input  logic [WIDTH-1:0]       wdata,
   input  logic [PORTS*AW-1:0]    raddr_flat,
   output logic [PORTS*WIDTH-1:0] rdata_flat
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (AW < IW) begin : g_bad_aw
      $error("spmv_store: address width too small for depth");
   end
   if (PORTS < 1) begin : g_bad_ports
      $error("spmv_store: needs at least one read port");
   end

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && (int'(waddr) < DEPTH)) mem[waddr[IW-1:0]] <= wdata;
   end

   for (genvar p = 0; p < PORTS; p++) begin : g_rd
      logic [AW-1:0] ra;
      assign ra = raddr_flat[p*AW +: AW];
      assign rdata_flat[p*WIDTH +: WIDTH] =
         (int'(ra) < DEPTH) ? mem[ra[IW-1:0]] : '0;
   end
endmodule

// File: rtl/spmv_dot.sv
module spmv_dot #(
   parameter int LANES = 4,
   parameter int DW    = 8,
   parameter int ACCW  = 19,
   parameter int RAW   = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_vld,
   input  logic [RAW-1:0]          in_row,
   input  logic [LANES*DW-1:0]     a_flat,
   input  logic [LANES*DW-1:0]     x_flat,
   output logic                    out_vld,
   output logic [RAW-1:0]          out_row,
   output logic signed [ACCW-1:0]  out_sum
);
   localparam int PW = 2 * DW;

   if (ACCW < PW + $clog2(LANES) + 1) begin : g_bad_accw
      $error("spmv_dot: accumulator too narrow for lane count");
   end

   logic signed [PW-1:0] prod_q [LANES];
   logic                 vld_q;
   logic [RAW-1:0]       row_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic signed [DW-1:0] a_l, x_l;
      assign a_l = a_flat[l*DW +: DW];
      assign x_l = x_flat[l*DW +: DW];
      always_ff @(posedge clk) begin
         if (in_vld) prod_q[l] <= a_l * x_l;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= 1'b0;
         row_q <= '0;
      end else begin
         vld_q <= in_vld;
         if (in_vld) row_q <= in_row;
      end
   end

   always_comb begin
      out_sum = '0;
      for (int l = 0; l < LANES; l++) begin
         out_sum = out_sum + {{(ACCW-PW){prod_q[l][PW-1]}}, prod_q[l]};
      end
   end

   assign out_vld = vld_q;
   assign out_row = row_q;

   AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
      (out_vld && $past(out_vld)) |-> (out_row == RAW'($past(out_row) + 1'b1))); // R2
endmodule

// File: rtl/spmv_csr_top.sv
module spmv_csr_top
   import spmv_pkg::*;
#(
   parameter int N_ROWS = 16,
   parameter int N_COLS = 16,
   parameter int NZ_ROW = 4,
   parameter int DW     = 8,
   parameter int ACCW   = 19,
   parameter int CNTW   = 11,
   localparam int NNZ   = N_ROWS * NZ_ROW,
   localparam int NAW   = $clog2(NNZ),
   localparam int RAW   = $clog2(N_ROWS),
   localparam int CIW   = $clog2(N_COLS)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   start,
   input  logic                   ld_en,
   input  logic [1:0]             ld_sel,
   input  logic [NAW-1:0]         ld_addr,
   input  logic [DW-1:0]          ld_data,
   input  logic [RAW-1:0]         rd_addr,
   output logic signed [ACCW-1:0] rd_data,
   output logic                   done,
   output logic [CNTW-1:0]        cycle_count
);
   localparam int PTW = $clog2(NNZ + 1);

   if (N_COLS > NNZ) begin : g_bad_cols
      $error("spmv_csr_top: load address cannot reach every vector entry");
   end
   if ((1 << CNTW) <= N_ROWS + 1) begin : g_bad_cnt
      $error("spmv_csr_top: counter too narrow for one pass");
   end
   if (CIW > DW) begin : g_bad_ciw
      $error("spmv_csr_top: column index wider than load data");
   end

   // row-start table, N_ROWS+1 entries, fixed stride per row
   logic [PTW-1:0] row_ptr [N_ROWS+1];
   for (genvar g = 0; g <= N_ROWS; g++) begin : g_rptr
      assign row_ptr[g] = PTW'(g * NZ_ROW);
   end

   spmv_state_e    st;
   logic           running, iss_act;
   logic [RAW-1:0] ir;
   logic [CNTW-1:0] cnt;
   logic           iss_last;

   assign running  = (st == ST_RUN);
   assign iss_last = (row_ptr[{1'b0, ir} + 1'b1] == row_ptr[N_ROWS]);

   // load gating
   logic vec_we, val_we, col_we;
   assign vec_we = ld_en && !running && (ld_sel == LD_VEC);
   assign val_we = ld_en && !running && (ld_sel == LD_VAL);
   assign col_we = ld_en && !running && (ld_sel == LD_COL);

   // lane addressing
   logic [NZ_ROW*PTW-1:0] slot_addr;
   for (genvar l = 0; l < NZ_ROW; l++) begin : g_slot
      assign slot_addr[l*PTW +: PTW] = row_ptr[ir] + PTW'(l);
   end

   logic [NZ_ROW*DW-1:0]  val_rd;
   logic [NZ_ROW*CIW-1:0] col_rd;
   logic [NZ_ROW*DW-1:0]  vec_rd;

   spmv_store #(.DEPTH(NNZ), .WIDTH(DW), .AW(PTW), .PORTS(NZ_ROW)) u_val (
      .clk(clk), .we(val_we), .waddr(PTW'(ld_addr)), .wdata(ld_data),
      .raddr_flat(slot_addr), .rdata_flat(val_rd));

   spmv_store #(.DEPTH(NNZ), .WIDTH(CIW), .AW(PTW), .PORTS(NZ_ROW)) u_col (
      .clk(clk), .we(col_we), .waddr(PTW'(ld_addr)), .wdata(ld_data[CIW-1:0]),
      .raddr_flat(slot_addr), .rdata_flat(col_rd));

   spmv_store #(.DEPTH(N_COLS), .WIDTH(DW), .AW(CIW), .PORTS(NZ_ROW)) u_vec (
      .clk(clk), .we(vec_we), .waddr(ld_addr[CIW-1:0]), .wdata(ld_data),
      .raddr_flat(col_rd), .rdata_flat(vec_rd));

   logic                   d_vld;
   logic [RAW-1:0]         d_row;
   logic signed [ACCW-1:0] d_sum;

   spmv_dot #(.LANES(NZ_ROW), .DW(DW), .ACCW(ACCW), .RAW(RAW)) u_dot (
      .clk(clk), .rst(rst), .in_vld(running && iss_act), .in_row(ir),
      .a_flat(val_rd), .x_flat(vec_rd),
      .out_vld(d_vld), .out_row(d_row), .out_sum(d_sum));

   // sequencer
   always_ff @(posedge clk) begin
      if (rst) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         iss_act <= 1'b0;
         ir      <= '0;
      end else begin
         unique case (st)
            ST_RUN: begin
               cnt <= cnt + 1'b1;
               if (iss_act) begin
                  ir <= ir + 1'b1;
                  if (iss_last) iss_act <= 1'b0;
               end
               if (d_vld && (d_row == RAW'(N_ROWS - 1))) st <= ST_DONE;
            end
            default: begin
               if (start) begin
                  st      <= ST_RUN;
                  cnt     <= '0;
                  iss_act <= 1'b1;
                  ir      <= '0;
               end
            end
         endcase
      end
   end

   // result memory, untouched by reset
   logic signed [ACCW-1:0] res_mem [N_ROWS];
   always_ff @(posedge clk) begin
      if (d_vld) res_mem[d_row] <= d_sum;
   end

   assign rd_data     = res_mem[rd_addr];
   assign done        = (st == ST_DONE);
   assign cycle_count = cnt;

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (start && !running) |=> (cycle_count == '0 && !done)); // R4
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      running |=> (cycle_count == CNTW'($past(cycle_count) + 1'b1))); // R4
   AST_PASS_LENGTH: assert property (@(posedge clk) disable iff (rst)
      (running && cycle_count == CNTW'(N_ROWS)) |=> done); // R4
   AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> (done && $stable(cycle_count))); // R5
   AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (rst)
      (running && cycle_count < CNTW'(N_ROWS)) |=> !done); // R6
endmodule

// File: tb/tb_spmv_csr_top.sv
module tb_spmv_csr_top;
   localparam int NR = 16, NC = 16, NZ = 4, NNZ = NR * NZ;
   localparam int PASS_CYC = NR + 1;

   logic clk = 1'b0, rst = 1'b1, start = 1'b0, ld_en = 1'b0;
   logic [1:0] ld_sel = 2'd3;
   logic [5:0] ld_addr = '0;
   logic [7:0] ld_data = '0;
   logic [3:0] rd_addr = '0;
   logic signed [18:0] rd_data;
   logic done;
   logic [10:0] cycle_count;

   int n_tests = 0, n_fail = 0;
   int vec [NC];
   int val [NNZ];
   int col [NNZ];
   int exp_y [NR];
   bit finished = 1'b0;

   always #5 clk = ~clk;

   spmv_csr_top dut (.clk(clk), .rst(rst), .start(start), .ld_en(ld_en),
      .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .done(done), .cycle_count(cycle_count));

   task automatic check(input string req, input int act, input int expv);
      n_tests++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(10 * 200000);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   task automatic load1(input int sel, input int addr, input int data);
      @(negedge clk);
      ld_en = 1'b1; ld_sel = 2'(sel); ld_addr = 6'(addr); ld_data = 8'(data);
      @(negedge clk);
      ld_en = 1'b0; ld_sel = 2'd3;
   endtask

   task automatic load_all();
      for (int i = 0; i < NC; i++) load1(0, i, vec[i]);
      for (int k = 0; k < NNZ; k++) load1(1, k, val[k]);
      for (int k = 0; k < NNZ; k++) load1(2, k, col[k]);
   endtask

   // reference through the dense matrix rebuilt from the compressed form
   task automatic compute_ref();
      int dense [NR][NC];
      for (int r = 0; r < NR; r++)
         for (int c = 0; c < NC; c++) dense[r][c] = 0;
      for (int r = 0; r < NR; r++)
         for (int l = 0; l < NZ; l++)
            dense[r][col[r*NZ+l]] += val[r*NZ+l];
      for (int r = 0; r < NR; r++) begin
         exp_y[r] = 0;
         for (int c = 0; c < NC; c++) exp_y[r] += dense[r][c] * vec[c];
      end
   endtask

   // mode: 0 plain, 1 start pulse mid-pass, 2 vector load mid-pass
   task automatic run_pass(input string req, input int mode);
      int lat;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check({req, "/R4 count zero after start"}, int'(cycle_count), 0);
      lat = 0;
      while (!done && lat < 100) begin
         if (mode == 1) start = (lat == 5);
         if (mode == 2) begin
            ld_en = (lat >= 3 && lat < 7);
            ld_sel = 2'd0; ld_addr = 6'(lat); ld_data = 8'(lat * 17 + 3);
         end
         @(negedge clk);
         lat++;
         start = 1'b0; ld_en = 1'b0; ld_sel = 2'd3;
      end
      check({req, "/R4 done latency"}, lat, PASS_CYC);
      check({req, "/R4 final count"}, int'(cycle_count), PASS_CYC);
   endtask

   task automatic check_outputs(input string req);
      for (int r = 0; r < NR; r++) begin
         rd_addr = 4'(r);
         #1;
         check(req, int'(rd_data), exp_y[r]);
      end
   endtask

   task automatic rand_data(input bit dup);
      for (int i = 0; i < NC; i++) vec[i] = int'($signed(8'($urandom)));
      for (int k = 0; k < NNZ; k++) begin
         val[k] = int'($signed(8'($urandom)));
         col[k] = dup ? ((k / NZ) % 2 == 0 ? (k / NZ) % NC : int'($urandom % 2)) : int'($urandom % NC);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 done", int'(done), 0);
      check("R1 count", int'(cycle_count), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 done after release", int'(done), 0);

      // R2 random sweeps
      for (int p = 0; p < 12; p++) begin
         rand_data(1'b0);
         load_all();
         compute_ref();
         run_pass("R2", 0);
         check_outputs("R2 row result");
      end

      // R3 extremes
      for (int i = 0; i < NC; i++) vec[i] = -128;
      for (int k = 0; k < NNZ; k++) begin val[k] = -128; col[k] = k % NC; end
      load_all(); compute_ref(); run_pass("R3", 0);
      check_outputs("R3 all -128");
      for (int i = 0; i < NC; i++) vec[i] = (i % 2) ? 127 : -128;
      for (int k = 0; k < NNZ; k++) begin val[k] = (k % 2) ? -128 : 127; col[k] = (k * 5) % NC; end
      load_all(); compute_ref(); run_pass("R3", 0);
      check_outputs("R3 mixed extremes");

      // R9 repeated column indices
      for (int p = 0; p < 3; p++) begin
         rand_data(1'b1);
         load_all(); compute_ref(); run_pass("R9", 0);
         check_outputs("R9 duplicate index");
      end

      // R5 hold after done
      repeat (10) @(negedge clk);
      check("R5 done held", int'(done), 1);
      check("R5 count held", int'(cycle_count), PASS_CYC);

      // R6 start during pass ignored
      rand_data(1'b0); load_all(); compute_ref();
      run_pass("R6", 1);
      check_outputs("R6 results");

      // R7 load during pass ignored; also ld_sel 3 writes nothing
      run_pass("R7", 2);
      check_outputs("R7 results after busy load");
      load1(3, 0, 99);
      run_pass("R7", 0);
      check_outputs("R7 results after rerun");

      // R8 reset keeps stores and output memory
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      check("R8 done cleared", int'(done), 0);
      check_outputs("R8 output kept over reset");
      @(negedge clk); start = 1'b1;
      repeat (4) @(negedge clk);
      start = 1'b0; rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      run_pass("R8", 0);
      check_outputs("R8 stores kept over reset");

      finish_run();
   end
endmodule